// File: doc/BRIEF.md
# Conditional Branch Evaluation Unit

This block takes one decoded jump-class instruction and decides its control-flow outcome. It receives the 4-bit jump code, the operand-source bit (register or immediate), a width flag that selects 64-bit or 32-bit comparison, the two register values, the 16-bit offset, the 32-bit immediate and the current program counter. The program counter counts 64-bit instruction slots. The block reports whether the branch is taken and gives the next program counter. It also marks call instructions, exit instructions and undefined encodings. It does not carry out calls or returns. It only identifies them.

A small controller runs the block. In state `ST_IDLE` it waits for `req_valid`. An accepted request moves it to `ST_EVAL` (transition *accept*). In that cycle the comparison and the target adder work on the captured fields, and the results are registered (transition *commit*). The controller then enters `ST_DONE`, where `res_valid` is high for exactly one cycle. From there it returns to `ST_IDLE` (transition *release*). Requests that arrive in `ST_EVAL` or `ST_DONE` are dropped, so a caller issues at most one request every three cycles. Two comparator lanes run side by side: one is the full register width and one is the low half. The width flag picks which lane's verdict is used.

Top module: `bcu_branch_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first result, `res_valid`, `res_taken`, `res_call`, `res_exit` and `res_illegal` are 0 and `res_next_pc` is 0.
- R2: A request sampled with `req_valid`=1 in the idle state produces exactly one result cycle: `res_valid` goes high one cycle after the next rising edge following acceptance and stays high for a single cycle. Requests sampled during the two busy cycles produce no result. Result outputs hold their values after `res_valid` falls.
- R3: `req_src_reg`=1 takes the source register as the second operand. `req_src_reg`=0 takes the immediate sign-extended to 64 bits. Code 0x1 is taken on equality, 0x5 on inequality, and 0x4 when the bitwise AND of the operands is nonzero.
- R4: Unsigned conditions: 0x2 greater, 0x3 greater-or-equal, 0xa less, 0xb less-or-equal.
- R5: Signed (two's complement) conditions: 0x6 greater, 0x7 greater-or-equal, 0xc less, 0xd less-or-equal.
- R6: With `req_narrow`=1, only bits 31:0 of both operands are compared, and signed conditions use bit 31 as the sign. Example: code 0x7 with a register source and the narrow class compares the low words as signed values.
- R7: Code 0x0 is always taken. With `req_narrow`=0 the displacement is the sign-extended 16-bit offset. With `req_narrow`=1 it is the sign-extended 32-bit immediate.
- R8: For a taken branch, `res_next_pc` = pc + 1 + displacement. Otherwise it is pc + 1. Both wrap modulo 2^PC_W. Conditional codes use the sign-extended offset.
- R9: Code 0x8 sets `res_call` and is not taken.
- R10: Code 0x9 with `req_narrow`=0 sets `res_exit` and is not taken. With `req_narrow`=1 it sets `res_illegal` instead.
- R11: Codes 0xe and 0xf set `res_illegal`, are not taken, and give pc + 1.
- R12: In a result cycle, at most one of `res_taken`, `res_call`, `res_exit`, `res_illegal` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Instruction present this cycle |
| req_code | input | 4 | Jump operation code |
| req_src_reg | input | 1 | 1: second operand is source register; 0: immediate |
| req_narrow | input | 1 | 1: 32-bit comparison class; 0: 64-bit class |
| req_dst_val | input | XLEN | Destination register value |
| req_src_val | input | XLEN | Source register value |
| req_offset | input | OFF_W | Signed branch offset |
| req_imm | input | IMM_W | Signed immediate |
| req_pc | input | PC_W | Program counter in instruction slots |
| res_valid | output | 1 | Result cycle marker |
| res_taken | output | 1 | Branch taken |
| res_next_pc | output | PC_W | Next program counter |
| res_call | output | 1 | Instruction is a call |
| res_exit | output | 1 | Instruction is an exit |
| res_illegal | output | 1 | Undefined encoding |

## Verification
The bench targets operands that differ only above bit 31. A design that ignores the narrow flag gets these wrong, and so does one that compares narrow operands as unsigned. It also uses an immediate of all ones against a register of all ones, which exposes a design that zero-extends the immediate. Other cases are a wide backward jump, an unconditional narrow jump whose displacement is larger than 16 bits, and wrap-around of the program counter. A design that picks the wrong displacement field or mishandles the carry reports the wrong target. Requests are held high through the busy cycles, and exit is issued in the narrow class. A controller that re-accepts, or that treats a narrow exit as legal, produces extra results or wrong flags.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

    typedef enum logic [3:0] {
        JC_ALWAYS = 4'h0,
        JC_EQ     = 4'h1,
        JC_UGT    = 4'h2,
        JC_UGE    = 4'h3,
        JC_TEST   = 4'h4,
        JC_NE     = 4'h5,
        JC_SGT    = 4'h6,
        JC_SGE    = 4'h7,
        JC_CALL   = 4'h8,
        JC_EXIT   = 4'h9,
        JC_ULT    = 4'ha,
        JC_ULE    = 4'hb,
        JC_SLT    = 4'hc,
        JC_SLE    = 4'hd
    } jcode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_DONE = 2'd2
    } state_e;

    typedef struct packed {
        logic taken;
        logic uncond;
        logic call;
        logic quit;
        logic illegal;
    } verdict_t;

    localparam int LANES = 2;

endpackage

// File: rtl/bcu_cmp_lane.sv
module bcu_cmp_lane #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         eq,
    output logic         ult,
    output logic         slt,
    output logic         tst
);
    always_comb begin
        eq  = (a == b);
        ult = (a < b);
        slt = ($signed(a) < $signed(b));
        tst = |(a & b);
    end
endmodule

// File: rtl/bcu_cond.sv
module bcu_cond
    import bcu_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = 32
) (
    input  logic [3:0]       code,
    input  logic             src_reg,
    input  logic             narrow,
    input  logic [XLEN-1:0]  dst_val,
    input  logic [XLEN-1:0]  src_val,
    input  logic [IMM_W-1:0] imm,
    output verdict_t         verdict
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0]  imm_ext;
    logic [XLEN-1:0]  opnd_b;
    logic [LANES-1:0] lane_eq, lane_ult, lane_slt, lane_tst;
    logic             eq, ult, slt, tst;

    assign imm_ext = XLEN'($signed(imm));
    assign opnd_b  = src_reg ? src_val : imm_ext;

    // lane 0 is full width, lane 1 is the low half
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LW = (g == 0) ? XLEN : HALF;
        bcu_cmp_lane #(.W(LW)) u_lane (
            .a   (dst_val[LW-1:0]),
            .b   (opnd_b[LW-1:0]),
            .eq  (lane_eq[g]),
            .ult (lane_ult[g]),
            .slt (lane_slt[g]),
            .tst (lane_tst[g])
        );
    end

    always_comb begin
        eq  = narrow ? lane_eq[1]  : lane_eq[0];
        ult = narrow ? lane_ult[1] : lane_ult[0];
        slt = narrow ? lane_slt[1] : lane_slt[0];
        tst = narrow ? lane_tst[1] : lane_tst[0];
    end

    always_comb begin
        verdict = '0;
        case (jcode_e'(code))
            JC_ALWAYS: begin
                verdict.taken  = 1'b1;
                verdict.uncond = 1'b1;
            end
            JC_EQ:   verdict.taken = eq;
            JC_NE:   verdict.taken = ~eq;
            JC_TEST: verdict.taken = tst;
            JC_UGT:  verdict.taken = ~ult & ~eq;
            JC_UGE:  verdict.taken = ~ult;
            JC_ULT:  verdict.taken = ult;
            JC_ULE:  verdict.taken = ult | eq;
            JC_SGT:  verdict.taken = ~slt & ~eq;
            JC_SGE:  verdict.taken = ~slt;
            JC_SLT:  verdict.taken = slt;
            JC_SLE:  verdict.taken = slt | eq;
            JC_CALL: verdict.call  = 1'b1;
            JC_EXIT: begin
                if (narrow) verdict.illegal = 1'b1;
                else        verdict.quit    = 1'b1;
            end
            default: verdict.illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/bcu_target.sv
module bcu_target #(
    parameter int PC_W  = 32,
    parameter int OFF_W = 16,
    parameter int IMM_W = 32
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    input  logic [IMM_W-1:0] imm,
    input  logic             use_imm,
    input  logic             taken,
    output logic [PC_W-1:0]  next_pc
);
    logic [PC_W-1:0] disp;
    logic [PC_W-1:0] seq_pc;

    always_comb begin
        disp    = use_imm ? PC_W'($signed(imm)) : PC_W'($signed(offset));
        seq_pc  = pc + PC_W'(1);
        next_pc = taken ? (seq_pc + disp) : seq_pc;
    end
endmodule

// File: rtl/bcu_ctrl.sv
module bcu_ctrl
    import bcu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    output logic capture,
    output logic commit,
    output logic done
);
    state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        capture  = 1'b0;
        commit   = 1'b0;
        done     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    capture  = 1'b1;
                    state_nx = ST_EVAL;
                end
            end
            ST_EVAL: begin
                commit   = 1'b1;
                state_nx = ST_DONE;
            end
            ST_DONE: begin
                done     = 1'b1;
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/bcu_branch_unit.sv
module bcu_branch_unit
    import bcu_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int PC_W  = 32,
    parameter int OFF_W = 16,
    parameter int IMM_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [3:0]       req_code,
    input  logic             req_src_reg,
    input  logic             req_narrow,
    input  logic [XLEN-1:0]  req_dst_val,
    input  logic [XLEN-1:0]  req_src_val,
    input  logic [OFF_W-1:0] req_offset,
    input  logic [IMM_W-1:0] req_imm,
    input  logic [PC_W-1:0]  req_pc,
    output logic             res_valid,
    output logic             res_taken,
    output logic [PC_W-1:0]  res_next_pc,
    output logic             res_call,
    output logic             res_exit,
    output logic             res_illegal
);
    logic             capture, commit, done;
    logic [3:0]       h_code;
    logic             h_src_reg, h_narrow;
    logic [XLEN-1:0]  h_dst, h_src;
    logic [OFF_W-1:0] h_off;
    logic [IMM_W-1:0] h_imm;
    logic [PC_W-1:0]  h_pc;
    verdict_t         verdict;
    logic [PC_W-1:0]  tgt_pc;

    bcu_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .capture   (capture),
        .commit    (commit),
        .done      (done)
    );

    // hold the instruction while it is evaluated
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_code    <= '0;
            h_src_reg <= 1'b0;
            h_narrow  <= 1'b0;
            h_dst     <= '0;
            h_src     <= '0;
            h_off     <= '0;
            h_imm     <= '0;
            h_pc      <= '0;
        end else if (capture) begin
            h_code    <= req_code;
            h_src_reg <= req_src_reg;
            h_narrow  <= req_narrow;
            h_dst     <= req_dst_val;
            h_src     <= req_src_val;
            h_off     <= req_offset;
            h_imm     <= req_imm;
            h_pc      <= req_pc;
        end
    end

    bcu_cond #(.XLEN(XLEN), .IMM_W(IMM_W)) u_cond (
        .code    (h_code),
        .src_reg (h_src_reg),
        .narrow  (h_narrow),
        .dst_val (h_dst),
        .src_val (h_src),
        .imm     (h_imm),
        .verdict (verdict)
    );

    bcu_target #(.PC_W(PC_W), .OFF_W(OFF_W), .IMM_W(IMM_W)) u_target (
        .pc      (h_pc),
        .offset  (h_off),
        .imm     (h_imm),
        .use_imm (verdict.uncond & h_narrow),
        .taken   (verdict.taken),
        .next_pc (tgt_pc)
    );

    // output registers, loaded on the commit transition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_taken   <= 1'b0;
            res_next_pc <= '0;
            res_call    <= 1'b0;
            res_exit    <= 1'b0;
            res_illegal <= 1'b0;
        end else if (commit) begin
            res_taken   <= verdict.taken;
            res_next_pc <= tgt_pc;
            res_call    <= verdict.call;
            res_exit    <= verdict.quit;
            res_illegal <= verdict.illegal;
        end
    end

    assign res_valid = done;
endmodule

// File: rtl/bcu_branch_unit_chk.sv
module bcu_branch_unit_chk #(
    parameter int XLEN  = 64,
    parameter int PC_W  = 32,
    parameter int OFF_W = 16,
    parameter int IMM_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [3:0]       req_code,
    input logic             req_src_reg,
    input logic             req_narrow,
    input logic [XLEN-1:0]  req_dst_val,
    input logic [XLEN-1:0]  req_src_val,
    input logic [OFF_W-1:0] req_offset,
    input logic [IMM_W-1:0] req_imm,
    input logic [PC_W-1:0]  req_pc,
    input logic             res_valid,
    input logic             res_taken,
    input logic [PC_W-1:0]  res_next_pc,
    input logic             res_call,
    input logic             res_exit,
    input logic             res_illegal
);
    AST_SINGLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R2

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> $stable(res_next_pc) && $stable(res_taken)); // R2

    AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_taken |-> res_next_pc == $past(req_pc, 2) + PC_W'(1)); // R8

    AST_CALL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && $past(req_code, 2) == 4'h8 |-> res_call && !res_taken); // R9

    AST_EXIT_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_exit |-> !$past(req_narrow, 2)); // R10

    AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && $past(req_code, 2) >= 4'he |-> res_illegal && !res_taken); // R11

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $onehot0({res_taken, res_call, res_exit, res_illegal})); // R12
endmodule

bind bcu_branch_unit bcu_branch_unit_chk #(
    .XLEN(XLEN), .PC_W(PC_W), .OFF_W(OFF_W), .IMM_W(IMM_W)
) u_chk (.*);

// File: tb/bcu_branch_unit_test.sv
`timescale 1ns/1ps
module bcu_branch_unit_test;
    localparam int XLEN = 64, PC_W = 32, OFF_W = 16, IMM_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [3:0]       req_code = '0;
    logic             req_src_reg = 1'b0;
    logic             req_narrow = 1'b0;
    logic [XLEN-1:0]  req_dst_val = '0;
    logic [XLEN-1:0]  req_src_val = '0;
    logic [OFF_W-1:0] req_offset = '0;
    logic [IMM_W-1:0] req_imm = '0;
    logic [PC_W-1:0]  req_pc = '0;
    logic             res_valid, res_taken, res_call, res_exit, res_illegal;
    logic [PC_W-1:0]  res_next_pc;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic            taken, call, quit, illegal;
        logic [PC_W-1:0] npc;
        string           tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    bcu_branch_unit uut (.*);

    function automatic exp_t model(input logic [3:0] code, input logic nar,
                                   input logic sreg, input logic [63:0] d,
                                   input logic [63:0] s, input logic [15:0] off,
                                   input logic [31:0] imm, input logic [31:0] pc,
                                   input string tag);
        exp_t e;
        logic [63:0] a, b;
        logic signed [63:0] sa, sb2;
        logic [31:0] disp;
        e.taken = 0; e.call = 0; e.quit = 0; e.illegal = 0; e.tag = tag;
        b = sreg ? s : {{32{imm[31]}}, imm};
        a = d;
        if (nar) begin
            sa  = {{32{a[31]}}, a[31:0]};
            sb2 = {{32{b[31]}}, b[31:0]};
            a   = {32'b0, a[31:0]};
            b   = {32'b0, b[31:0]};
        end else begin
            sa = a; sb2 = b;
        end
        case (code)
            4'h0: e.taken = 1;
            4'h1: e.taken = (a == b);
            4'h5: e.taken = (a != b);
            4'h4: e.taken = ((a & b) != 0);
            4'h2: e.taken = (a > b);
            4'h3: e.taken = (a >= b);
            4'ha: e.taken = (a < b);
            4'hb: e.taken = (a <= b);
            4'h6: e.taken = (sa > sb2);
            4'h7: e.taken = (sa >= sb2);
            4'hc: e.taken = (sa < sb2);
            4'hd: e.taken = (sa <= sb2);
            4'h8: e.call = 1;
            4'h9: if (nar) e.illegal = 1; else e.quit = 1;
            default: e.illegal = 1;
        endcase
        disp = (code == 4'h0 && nar) ? imm : {{16{off[15]}}, off};
        e.npc = e.taken ? pc + 32'd1 + disp : pc + 32'd1;
        return e;
    endfunction

    task automatic drive(input logic [3:0] code, input logic nar, input logic sreg,
                         input logic [63:0] d, input logic [63:0] s,
                         input logic [15:0] off, input logic [31:0] imm,
                         input logic [31:0] pc);
        req_code = code; req_narrow = nar; req_src_reg = sreg;
        req_dst_val = d; req_src_val = s; req_offset = off; req_imm = imm;
        req_pc = pc;
    endtask

    task automatic send(input string tag, input logic [3:0] code, input logic nar,
                        input logic sreg, input logic [63:0] d, input logic [63:0] s,
                        input logic [15:0] off, input logic [31:0] imm,
                        input logic [31:0] pc);
        @(negedge clk);
        drive(code, nar, sreg, d, s, off, imm, pc);
        req_valid = 1'b1;
        sb.push_back(model(code, nar, sreg, d, s, off, imm, pc, tag));
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            exp_t e;
            if (sb.size() == 0) begin
                checks++; errors++;
                $display("FAIL R2 unexpected result: got valid=1 expected valid=0");
            end else begin
                e = sb.pop_front();
                checks++;
                if ({res_taken, res_call, res_exit, res_illegal} !== {e.taken, e.call, e.quit, e.illegal}
                    || res_next_pc !== e.npc) begin
                    errors++;
                    $display("FAIL %s got t=%0b c=%0b x=%0b i=%0b pc=%h expected t=%0b c=%0b x=%0b i=%0b pc=%h",
                             e.tag, res_taken, res_call, res_exit, res_illegal, res_next_pc,
                             e.taken, e.call, e.quit, e.illegal, e.npc);
                end
                checks++;
                if ($countones({res_taken, res_call, res_exit, res_illegal}) > 1) begin
                    errors++;
                    $display("FAIL R12 flags %b expected at most one set",
                             {res_taken, res_call, res_exit, res_illegal});
                end
            end
        end
    end

    initial begin
        #200000;
        errors++; checks++;
        $display("FAIL watchdog expired: got running expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if ({res_valid, res_taken, res_call, res_exit, res_illegal} !== 5'b0 || res_next_pc !== '0) begin
            errors++;
            $display("FAIL R1 reset outputs got %b pc=%h expected 0",
                     {res_valid, res_taken, res_call, res_exit, res_illegal}, res_next_pc);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || res_next_pc !== '0) begin
            errors++;
            $display("FAIL R1 after release got valid=%b pc=%h expected 0", res_valid, res_next_pc);
        end

        // R3 operand select and equality / bit test
        send("R3 eq reg", 4'h1, 0, 1, 64'h1234_5678_9abc_def0, 64'h1234_5678_9abc_def0, 16'd4, 32'd0, 32'd10);
        send("R3 eq imm sext", 4'h1, 0, 0, 64'hffff_ffff_ffff_ffff, 64'd0, 16'd2, 32'hffff_ffff, 32'd20);
        send("R3 ne", 4'h5, 0, 1, 64'd5, 64'd5, 16'd2, 32'd0, 32'd30);
        send("R3 test hit", 4'h4, 0, 1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0001, 16'd7, 32'd0, 32'd40);
        send("R3 test miss", 4'h4, 0, 0, 64'h0f, 64'd0, 16'd7, 32'h70, 32'd40);
        // R4 unsigned
        send("R4 ugt", 4'h2, 0, 1, 64'hffff_ffff_ffff_ffff, 64'd1, 16'd3, 32'd0, 32'd50);
        send("R4 uge eq", 4'h3, 0, 1, 64'd9, 64'd9, 16'd3, 32'd0, 32'd50);
        send("R4 ult", 4'ha, 0, 1, 64'd1, 64'hffff_ffff_ffff_ffff, 16'd3, 32'd0, 32'd50);
        send("R4 ule", 4'hb, 0, 1, 64'd10, 64'd9, 16'd3, 32'd0, 32'd50);
        // R5 signed
        send("R5 sgt", 4'h6, 0, 1, 64'hffff_ffff_ffff_ffff, 64'd1, 16'd3, 32'd0, 32'd60);
        send("R5 sge", 4'h7, 0, 0, 64'd0, 64'd0, 16'd3, 32'hffff_ffff, 32'd60);
        send("R5 slt", 4'hc, 0, 1, 64'h8000_0000_0000_0000, 64'd0, 16'd3, 32'd0, 32'd60);
        send("R5 sle eq", 4'hd, 0, 1, 64'd77, 64'd77, 16'd3, 32'd0, 32'd60);
        // R6 narrow class
        send("R6 narrow eq", 4'h1, 1, 1, 64'h1_0000_0005, 64'h2_0000_0005, 16'd8, 32'd0, 32'd70);
        send("R6 narrow sgt", 4'h6, 1, 1, 64'h0000_0000_8000_0000, 64'd1, 16'd8, 32'd0, 32'd70);
        send("R6 narrow sge 0x7e", 4'h7, 1, 1, 64'h0000_0000_ffff_ffff, 64'd0, 16'd8, 32'd0, 32'd70);
        send("R6 wide sge same ops", 4'h7, 0, 1, 64'h0000_0000_ffff_ffff, 64'd0, 16'd8, 32'd0, 32'd70);
        send("R6 narrow ult", 4'ha, 1, 1, 64'hffff_ffff_0000_0001, 64'h0000_0000_0000_0002, 16'd8, 32'd0, 32'd70);
        // R7 unconditional
        send("R7 wide back", 4'h0, 0, 0, 64'd0, 64'd0, 16'hfffd, 32'h0001_0000, 32'd100);
        send("R7 narrow imm", 4'h0, 1, 0, 64'd0, 64'd0, 16'h0004, 32'h0001_0000, 32'd5);
        // R8 target arithmetic
        send("R8 wrap seq", 4'h1, 0, 1, 64'd1, 64'd2, 16'd9, 32'd0, 32'hffff_ffff);
        send("R8 taken minus one", 4'h1, 0, 1, 64'd3, 64'd3, 16'hffff, 32'd0, 32'd200);
        // R9 / R10 / R11
        send("R9 call", 4'h8, 0, 0, 64'd0, 64'd0, 16'd0, 32'd5, 32'd300);
        send("R10 exit wide", 4'h9, 0, 0, 64'd0, 64'd0, 16'd0, 32'd0, 32'd301);
        send("R10 exit narrow", 4'h9, 1, 0, 64'd0, 64'd0, 16'd0, 32'd0, 32'd302);
        send("R11 code e", 4'he, 0, 1, 64'd1, 64'd1, 16'd5, 32'd0, 32'd400);
        send("R11 code f", 4'hf, 1, 1, 64'd1, 64'd1, 16'd5, 32'd0, 32'd401);

        // R2 requests during busy cycles are dropped
        @(negedge clk);
        drive(4'h1, 0, 1, 64'd4, 64'd4, 16'd1, 32'd0, 32'd500);
        req_valid = 1'b1;
        sb.push_back(model(4'h1, 0, 1, 64'd4, 64'd4, 16'd1, 32'd0, 32'd500, "R2 first of burst"));
        @(negedge clk);
        drive(4'hf, 0, 1, 64'd0, 64'd0, 16'd0, 32'd0, 32'd900);
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);

        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R2 pending results got %0d expected 0", sb.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule